// File: doc/BRIEF.md
# Free-Node Chaining Allocator

This block hands out and takes back node slots in one stage of a pipelined tree memory. It keeps no free list and no occupancy bitmap. A single head register names the next free slot. Every slot that is not in use holds a relative offset to the next free slot, so the free slots form a chain inside the node memory itself.

A memory filled with zeros is already a valid chain in which every slot points to its neighbour. Allocation therefore starts as a plain bump allocator at address 1, because address 0 means "no node". Freed slots are pushed onto the front of the chain. They come back in last-freed, first-reused order before the bump region grows again.

The block drives a single-port node memory that has one-cycle read latency and makes at most one access per cycle. An allocation takes two cycles: the first reads the offset stored at the head, the second writes zero into the claimed slot and moves the head. A free takes one write cycle. Its offset comes from the head register, so it needs no read.

Top module: `fnc_alloc`

## Requirements
- R1: After reset the head is address 1: the first allocation returns 1, `allocReady` and `freeReady` are high, and `full` and `memEn` are low.
- R2: On an untouched (all-zero) memory, successive allocations return 1, 2, 3, … in order.
- R3: An accepted allocation reads address head in its acceptance cycle (`memEn`=1, `memWe`=0). In the next cycle it writes 0 to the same address, with `allocDone`=1 and `allocAddr` equal to that address. `allocReady` and `freeReady` are both low in that second cycle.
- R4: After an allocation the new head is old head + offset read + 1, modulo 2^ADDR_W.
- R5: An accepted free of a non-zero address a performs a single write of (head − a − 1) mod 2^ADDR_W to address a in its acceptance cycle. The head becomes a, so the next allocation returns a.
- R6: Offsets wrap modulo 2^ADDR_W, so a chain stays correct when a slot is freed above the current head.
- R7: The memory port never issues a write without the enable; each cycle carries at most one access.
- R8: When the head is at or beyond DEPTH, `full` is high and `allocReady` is low. An allocation request then makes no memory access and produces no `allocDone`. A free is still accepted and clears `full`.
- R9: When allocate and free requests arrive in the same idle cycle and an allocation can be accepted, the allocation wins and `freeReady` is low.
- R10: A free of address 0 is accepted but makes no memory access and leaves the head unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocation request |
| allocReady | output | 1 | Allocation can be accepted this cycle |
| allocDone | output | 1 | Allocated address is valid this cycle |
| allocAddr | output | ADDR_W | Address being allocated (head) |
| freeValid | input | 1 | Free request |
| freeReady | output | 1 | Free can be accepted this cycle |
| freeAddr | input | ADDR_W | Address to release |
| full | output | 1 | No slot left to allocate |
| memEn | output | 1 | Node memory access enable |
| memWe | output | 1 | Node memory write enable |
| memAddr | output | ADDR_W | Node memory address |
| memWdata | output | ADDR_W | Offset value written |
| memRdata | input | ADDR_W | Offset value read, one cycle after the read |

## Verification
The assertions check every cycle that:
- each read is followed by the claim write to the same slot with zero data;
- both readies drop during the claim cycle;
- a free moves the head to the freed address;
- a full head refuses allocations;
- allocation takes priority over a free arriving in the same cycle;
- a null free never touches memory.

The actual chain behaviour can only be shown by the bench's scenarios, which compare every returned address against an independent model of a stack over a bump pointer. These scenarios cover:
- the linear start on a fresh memory;
- reuse of freed slots in last-freed, first-reused order;
- offsets that wrap when a slot above the head is freed;
- filling to DEPTH and recovering from the full state.

// File: rtl/fnc_alloc_pkg.sv
package fnc_alloc_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_CLAIM = 1'b1
  } fnc_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic readHead;    // issue read of offset at head
    logic claimHead;   // write 0 at head, advance head by offset+1
    logic releaseNode; // write chain offset at freeAddr, head <= freeAddr
  } fnc_strobe_t;

endpackage

// File: rtl/fnc_alloc_ctrl.sv
module fnc_alloc_ctrl
  import fnc_alloc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        allocValid,
  input  logic        freeValid,
  input  logic        freeIsNull,
  input  logic        isFull,
  output fnc_strobe_t strobe,
  output logic        allocReady,
  output logic        freeReady,
  output logic        allocDone,
  output logic        memEn,
  output logic        memWe
);

  fnc_state_t state, stateNext;
  logic idle;
  logic allocTake;
  logic freeTake;

  assign idle      = (state == ST_IDLE);
  assign allocReady = idle && !isFull;
  assign allocTake = allocValid && allocReady;
  // allocation has priority over a simultaneous free
  assign freeReady = idle && !allocTake;
  assign freeTake  = freeValid && freeReady && !freeIsNull;

  always_comb begin
    strobe             = '0;
    strobe.readHead    = allocTake;
    strobe.claimHead   = (state == ST_CLAIM);
    strobe.releaseNode = freeTake;
  end

  assign memEn     = strobe.readHead || strobe.claimHead || strobe.releaseNode;
  assign memWe     = strobe.claimHead || strobe.releaseNode;
  assign allocDone = strobe.claimHead;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (allocTake) stateNext = ST_CLAIM;
      ST_CLAIM: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/fnc_alloc_dpath.sv
module fnc_alloc_dpath
  import fnc_alloc_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DEPTH  = 32767
) (
  input  logic              clk,
  input  logic              rstN,
  input  fnc_strobe_t       strobe,
  input  logic [ADDR_W-1:0] freeAddr,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] headAddr,
  output logic              isFull,
  output logic              freeIsNull,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata
);

  localparam logic [ADDR_W-1:0] FIRST_ADDR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] LIMIT      = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] ONE        = ADDR_W'(1);

  logic [ADDR_W-1:0] headNext;
  logic [ADDR_W-1:0] chainOffset;

  assign isFull      = (headAddr >= LIMIT);
  assign freeIsNull  = (freeAddr == '0);
  // offset to the current head, wrapping modulo 2^ADDR_W
  assign chainOffset = headAddr - freeAddr - ONE;

  assign memAddr  = strobe.releaseNode ? freeAddr : headAddr;
  assign memWdata = strobe.releaseNode ? chainOffset : '0;

  always_comb begin
    headNext = headAddr;
    if (strobe.claimHead)        headNext = headAddr + memRdata + ONE;
    else if (strobe.releaseNode) headNext = freeAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) headAddr <= FIRST_ADDR;
    else       headAddr <= headNext;
  end

endmodule

// File: rtl/fnc_alloc.sv
module fnc_alloc
  import fnc_alloc_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DEPTH  = 32767
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  output logic              allocReady,
  output logic              allocDone,
  output logic [ADDR_W-1:0] allocAddr,
  input  logic              freeValid,
  output logic              freeReady,
  input  logic [ADDR_W-1:0] freeAddr,
  output logic              full,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic [ADDR_W-1:0] memRdata
);

  fnc_strobe_t       strobe;
  logic              isFull;
  logic              freeIsNull;
  logic [ADDR_W-1:0] headAddr;

  fnc_alloc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .allocValid (allocValid),
    .freeValid  (freeValid),
    .freeIsNull (freeIsNull),
    .isFull     (isFull),
    .strobe     (strobe),
    .allocReady (allocReady),
    .freeReady  (freeReady),
    .allocDone  (allocDone),
    .memEn      (memEn),
    .memWe      (memWe)
  );

  fnc_alloc_dpath #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .freeAddr   (freeAddr),
    .memRdata   (memRdata),
    .headAddr   (headAddr),
    .isFull     (isFull),
    .freeIsNull (freeIsNull),
    .memAddr    (memAddr),
    .memWdata   (memWdata)
  );

  assign allocAddr = headAddr;
  assign full      = isFull;

endmodule

// File: rtl/fnc_alloc_chk.sv
module fnc_alloc_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              allocValid,
  input logic              allocReady,
  input logic              allocDone,
  input logic [ADDR_W-1:0] allocAddr,
  input logic              freeValid,
  input logic              freeReady,
  input logic [ADDR_W-1:0] freeAddr,
  input logic              full,
  input logic              memEn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] memWdata
);

  AST_CLAIM_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe) |=> (allocDone && memWe && memAddr == $past(memAddr)
                           && allocAddr == $past(memAddr) && memWdata == '0)); // R3

  AST_CLAIM_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    allocDone |-> (!allocReady && !freeReady)); // R3

  AST_FREE_MOVES_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !allocDone) |=> (allocAddr == $past(memAddr))); // R5

  AST_WRITE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memEn); // R7

  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rstN)
    full |-> (!allocReady && !(memEn && !memWe))); // R8

  AST_ALLOC_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && allocReady && freeValid) |-> !freeReady); // R9

  AST_NULL_FREE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (freeValid && freeReady && freeAddr == '0) |-> !memEn); // R10

endmodule

bind fnc_alloc fnc_alloc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .allocValid (allocValid),
  .allocReady (allocReady),
  .allocDone  (allocDone),
  .allocAddr  (allocAddr),
  .freeValid  (freeValid),
  .freeReady  (freeReady),
  .freeAddr   (freeAddr),
  .full       (full),
  .memEn      (memEn),
  .memWe      (memWe),
  .memAddr    (memAddr),
  .memWdata   (memWdata)
);

// File: tb/test_fnc_alloc.sv
module test_fnc_alloc;

  localparam int AW    = 6;
  localparam int DEPTH = 20;
  localparam int MASK  = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          allocValid = 1'b0;
  logic          allocReady;
  logic          allocDone;
  logic [AW-1:0] allocAddr;
  logic          freeValid = 1'b0;
  logic          freeReady;
  logic [AW-1:0] freeAddr = '0;
  logic          full;
  logic          memEn;
  logic          memWe;
  logic [AW-1:0] memAddr;
  logic [AW-1:0] memWdata;
  logic [AW-1:0] memRdata;

  logic [AW-1:0] mem [0:(1<<AW)-1];

  int checks = 0;
  int fails  = 0;
  int expQ[$];
  int stack[$];
  int bump = 1;
  string curTag = "R2";
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  fnc_alloc #(.ADDR_W(AW), .DEPTH(DEPTH)) i_fnc_alloc (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocReady(allocReady), .allocDone(allocDone), .allocAddr(allocAddr),
    .freeValid(freeValid), .freeReady(freeReady), .freeAddr(freeAddr),
    .full(full), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // single-port node memory, one-cycle read latency
  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    memRdata = '0;
  end
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[memAddr] <= memWdata;
      else       memRdata <= mem[memAddr];
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int modelHead();
    return (stack.size() > 0) ? stack[stack.size()-1] : bump;
  endfunction

  // driver: accepted allocation
  task automatic doAlloc();
    @(negedge clk);
    checkEq("R3 allocReady before alloc", int'(allocReady), 1);
    allocValid = 1'b1;
    expQ.push_back(modelHead());
    #1;
    checkEq("R3 read issued", int'(memEn && !memWe), 1);
    checkEq("R3 read address is head", int'(memAddr), modelHead());
    if (stack.size() > 0) void'(stack.pop_back());
    else bump++;
    @(negedge clk);
    allocValid = 1'b0;
  endtask

  task automatic doFree(input int a);
    int h;
    @(negedge clk);
    h = modelHead();
    freeValid = 1'b1;
    freeAddr  = AW'(a);
    #1;
    checkEq("R5 freeReady", int'(freeReady), 1);
    if (a != 0) begin
      checkEq("R5 free writes", int'(memEn && memWe), 1);
      checkEq("R5 free address", int'(memAddr), a);
      checkEq("R6 free offset", int'(memWdata), (h - a - 1) & MASK);
      stack.push_back(a);
    end else begin
      checkEq("R10 null free no access", int'(memEn), 0);
    end
    @(negedge clk);
    freeValid = 1'b0;
  endtask

  // monitor: scoreboard of allocated addresses
  always @(negedge clk) begin
    if (rstN && allocDone) begin
      if (expQ.size() == 0) begin
        checkEq({curTag, " unexpected allocDone"}, 1, 0);
      end else begin
        checkEq({curTag, " allocated address"}, int'(allocAddr), expQ.pop_front());
        checkEq("R3 claim write of zero", int'(memWe && memWdata == '0), 1);
        checkEq("R3 readies low in claim", int'(allocReady || freeReady), 0);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkEq("R1 allocReady", int'(allocReady), 1);
    checkEq("R1 freeReady", int'(freeReady), 1);
    checkEq("R1 full", int'(full), 0);
    checkEq("R1 memEn", int'(memEn), 0);
    checkEq("R1 head", int'(allocAddr), 1);

    curTag = "R2";
    doAlloc(); doAlloc(); doAlloc();            // 1,2,3
    curTag = "R4";
    doFree(2); doAlloc(); doAlloc();            // 2, then 4
    doFree(3); doFree(1);
    doAlloc(); doAlloc(); doAlloc();            // 1,3,5
    curTag = "R6";
    doFree(3); doFree(5);                       // 5 above head 3: wrapped offset
    doAlloc(); doAlloc(); doAlloc();            // 5,3,6

    curTag = "R10";
    doFree(0);
    doAlloc();                                  // 7: head unchanged by null free

    // R9 simultaneous requests
    curTag = "R9";
    @(negedge clk);
    allocValid = 1'b1; freeValid = 1'b1; freeAddr = AW'(4);
    expQ.push_back(modelHead());
    bump++;
    #1;
    checkEq("R9 freeReady low", int'(freeReady), 0);
    checkEq("R9 read not write", int'(memEn && !memWe), 1);
    @(negedge clk);
    allocValid = 1'b0; freeValid = 1'b0;

    // R8 fill to DEPTH
    curTag = "R8";
    while (!(stack.size() == 0 && bump >= DEPTH)) doAlloc();
    @(negedge clk);
    checkEq("R8 full", int'(full), 1);
    checkEq("R8 allocReady low", int'(allocReady), 0);
    allocValid = 1'b1;
    #1;
    checkEq("R8 refused alloc no access", int'(memEn), 0);
    @(negedge clk);
    checkEq("R8 no allocDone", int'(allocDone), 0);
    allocValid = 1'b0;
    doFree(12);
    checkEq("R8 full cleared", int'(full), 0);
    doAlloc();                                  // 12
    @(negedge clk);
    checkEq("R8 full again", int'(full), 1);
    checkEq("R7 scoreboard drained", expQ.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule